// File: doc/BRIEF.md
# Internal Oscillator Rate Selector

This block picks the system clock rate for a chip whose clock comes from an on-die oscillator block. It takes two tick inputs in the `clk` domain: a fast tick that stands for an 8 MHz reference and a slow tick that stands for a separate 31.25 kHz source. It turns them into a single clock-enable pulse train. A 3-bit rate field, which software may rewrite at any moment, selects either the slow source or the fast source divided by a power of two, from 1 up to 64.

The block also sequences every change of rate at run time. There are two sequences, and the old setting decides which one runs. Leaving the slow setting switches the output to the new rate at once, because the output keeps running during the change. It then holds the frequency-stable flag low for a long settling window. A change between two fast-derived rates leaves the flag high. The output stays on the old rate until eight falling edges of the new divided clock have been counted, and then hands over at a point where both divided clocks are low. A write of the slow setting takes effect immediately and does not touch the flag.

The clock-enable output is one `clk` cycle wide per output clock period. None of the pins carries a data stream, so there is no valid/ready pairing and no back-pressure. The write strobe is taken on every cycle it is high.

Top module: `osc_freq_select`

## Requirements
- R1: Out of reset the rate field reads 000, the output follows the slow tick and `freq_stable` is 0.
- R2: For a rate field value s from 1 to 7, `clk_en` pulses once every 2^(7-s) fast ticks. 7 gives every fast tick and 1 gives every 64th fast tick. Each pulse appears one cycle after the fast tick that produced it.
- R3: With rate field 000, `clk_en` pulses one cycle after each slow tick and never in response to the fast tick.
- R4: Writing a non-zero value while the field is 000 moves the output to the new rate at once: the first pulse follows within one new-rate period. `freq_stable` is 0 from the next cycle.
- R5: After leaving 000, `freq_stable` goes to 1 in the cycle after the STAB_TICKS-th fast tick counted from the write.
- R6: A write that moves between two non-zero values while `freq_stable` is 1 keeps `freq_stable` at 1. The output stays on the old rate until eight falling edges of the new divided clock have passed, so no new-rate period ends earlier than eight new-rate periods after the write.
- R7: During a change between fast-derived rates, every gap between `clk_en` pulses equals either the old period or the new period, so no short pulse is produced.
- R8: Writing 000 makes the output follow the slow tick from the next cycle and leaves `freq_stable` at its previous value, including during a settling window.
- R9: Writing the value the field already holds starts no sequence: a settling window in progress is not restarted, and the rate and the field do not change.
- R10: A new non-zero write during the settling window restarts the window from that write, still treated as a departure from 000, and the output moves to the newest rate.
- R11: A new non-zero write during a fast-to-fast change retargets that change and keeps the old rate active meanwhile. A write equal to the rate still active ends the change with no switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock; all ticks and the strobe are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | One-cycle pulse per period of the 8 MHz reference |
| slow_tick | input | 1 | One-cycle pulse per period of the 31.25 kHz source |
| sel_wr | input | 1 | Write strobe for the rate field |
| sel_wdata | input | 3 | New rate field value (000 slow, 001..111 fast divided by 64..1) |
| clk_en | output | 1 | Selected clock-enable, one cycle high per output period |
| freq_stable | output | 1 | High when the selected rate has settled |
| sel_q | output | 3 | Rate field as last written |

## Verification
The hardest state to reach from the ports is a write that lands in the middle of a sequence already running. One case is a second write inside the settling window. Another is a retarget, or a return to the active rate, while eight new-rate edges are still being counted. The stimulus reaches these by counting fast ticks or cycles after the first write, then issuing the second write at a chosen point. It then follows the flag rise tick by tick and records every gap between output pulses against the old and new periods, so an early switch or a short pulse shows up as a gap that fits neither period.

// File: rtl/osc_sel_pkg.sv
package osc_sel_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned TOP_SEL = (1 << SEL_W) - 1;
  localparam int unsigned EXP_MAX = TOP_SEL - 1;

  typedef logic [SEL_W-1:0] rate_sel_t;

  typedef enum logic [1:0] {
    SW_IDLE   = 2'd0,
    SW_WARMUP = 2'd1,
    SW_SETTLE = 2'd2,
    SW_ALIGN  = 2'd3
  } sw_state_t;

  localparam rate_sel_t SLOW_SEL = '0;

  // Divide exponent for a fast-derived setting; the slow code maps to 0 but is never used to index.
  function automatic rate_sel_t sel_to_exp(rate_sel_t s);
    if (s == SLOW_SEL) return '0;
    return rate_sel_t'(TOP_SEL) - s;
  endfunction
endpackage

// File: rtl/osc_postscaler.sv
module osc_postscaler #(
  parameter int unsigned STAGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  output logic [STAGES:0]   bound_vec
);
  logic [STAGES-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (fast_tick) div_cnt <= div_cnt + 1'b1;
  end

  // bound_vec[e] is high where the clock divided by 2^e has its falling edge.
  assign bound_vec[0] = 1'b1;
  for (genvar g = 1; g <= STAGES; g++) begin : g_tap
    assign bound_vec[g] = (div_cnt[g-1:0] == '0);
  end
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer #(
  parameter int unsigned TICKS = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic fast_tick,
  output logic done
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run && fast_tick && (cnt != LAST)) cnt <= cnt + 1'b1;
  end

  assign done = run && fast_tick && !restart && (cnt == LAST);
endmodule

// File: rtl/osc_edge_counter.sv
module osc_edge_counter #(
  parameter int unsigned EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic edge_tick,
  output logic reached
);
  localparam int unsigned CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(EDGES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (edge_tick && (cnt != LIMIT)) cnt <= cnt + 1'b1;
  end

  assign reached = (cnt == LIMIT);
endmodule

// File: rtl/osc_switch_ctrl.sv
module osc_switch_ctrl
  import osc_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  rate_sel_t wr_sel,
  input  logic      stab_done,
  input  logic      edges_reached,
  input  logic      align_ok,
  output rate_sel_t sel_q,
  output rate_sel_t act_sel,
  output logic      freq_stable,
  output logic      stab_restart,
  output logic      stab_run,
  output logic      edge_clear,
  output logic      edge_run
);
  sw_state_t state;
  logic wr_new, to_slow, from_slow, fast_retarget, back_to_act;

  assign wr_new        = wr_en && (wr_sel != sel_q);
  assign to_slow       = wr_new && (wr_sel == SLOW_SEL);
  // A write inside the warm-up window still counts as leaving the slow setting.
  assign from_slow     = wr_new && !to_slow && ((sel_q == SLOW_SEL) || (state == SW_WARMUP));
  assign fast_retarget = wr_new && !to_slow && !from_slow;
  assign back_to_act   = fast_retarget && (wr_sel == act_sel);

  assign stab_restart = from_slow;
  assign stab_run     = (state == SW_WARMUP);
  assign edge_clear   = wr_new;
  assign edge_run     = (state == SW_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= SLOW_SEL;
      act_sel     <= SLOW_SEL;
      state       <= SW_IDLE;
      freq_stable <= 1'b0;
    end else if (to_slow) begin
      sel_q   <= SLOW_SEL;
      act_sel <= SLOW_SEL;
      state   <= SW_IDLE;
    end else if (from_slow) begin
      sel_q       <= wr_sel;
      act_sel     <= wr_sel;
      state       <= SW_WARMUP;
      freq_stable <= 1'b0;
    end else if (back_to_act) begin
      sel_q <= wr_sel;
      state <= SW_IDLE;
    end else if (fast_retarget) begin
      sel_q <= wr_sel;
      state <= SW_SETTLE;
    end else begin
      case (state)
        SW_WARMUP: if (stab_done) begin
          freq_stable <= 1'b1;
          state       <= SW_IDLE;
        end
        SW_SETTLE: if (edges_reached) state <= SW_ALIGN;
        SW_ALIGN: if (align_ok) begin
          act_sel <= sel_q;
          state   <= SW_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/osc_freq_select.sv
module osc_freq_select
  import osc_sel_pkg::*;
#(
  parameter int unsigned STAB_TICKS   = 32000,
  parameter int unsigned SETTLE_EDGES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic             clk_en,
  output logic             freq_stable,
  output logic [SEL_W-1:0] sel_q
);
  logic [EXP_MAX:0] bound_vec;
  rate_sel_t        act_sel;
  logic             act_bound, tgt_bound, align_ok, edge_tick;
  logic             stab_restart, stab_run, stab_done;
  logic             edge_clear, edge_run, edges_reached;

  function automatic logic pick_bound(logic [EXP_MAX:0] v, rate_sel_t s);
    if (s == SLOW_SEL) return 1'b0;
    return v[sel_to_exp(s)];
  endfunction

  osc_postscaler #(.STAGES(EXP_MAX)) u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .bound_vec (bound_vec)
  );

  assign act_bound = pick_bound(bound_vec, act_sel);
  assign tgt_bound = pick_bound(bound_vec, sel_q);
  // Hand over only where both divided clocks fall together.
  assign align_ok  = fast_tick && act_bound && tgt_bound;
  assign edge_tick = edge_run && fast_tick && tgt_bound;

  osc_stab_timer #(.TICKS(STAB_TICKS)) u_stab (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (stab_restart),
    .run       (stab_run),
    .fast_tick (fast_tick),
    .done      (stab_done)
  );

  osc_edge_counter #(.EDGES(SETTLE_EDGES)) u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (edge_clear),
    .edge_tick (edge_tick),
    .reached   (edges_reached)
  );

  osc_switch_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (sel_wr),
    .wr_sel        (sel_wdata),
    .stab_done     (stab_done),
    .edges_reached (edges_reached),
    .align_ok      (align_ok),
    .sel_q         (sel_q),
    .act_sel       (act_sel),
    .freq_stable   (freq_stable),
    .stab_restart  (stab_restart),
    .stab_run      (stab_run),
    .edge_clear    (edge_clear),
    .edge_run      (edge_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_en <= 1'b0;
    else if (act_sel == SLOW_SEL) clk_en <= slow_tick;
    else clk_en <= fast_tick && act_bound;
  end
endmodule

// File: rtl/osc_freq_select_chk.sv
module osc_freq_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fast_tick,
  input logic       slow_tick,
  input logic       sel_wr,
  input logic [2:0] sel_wdata,
  input logic       clk_en,
  input logic       freq_stable,
  input logic [2:0] sel_q,
  input logic [2:0] act_sel,
  input logic       stab_done
);
  p_reset_values_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!freq_stable && (sel_q == 3'd0)));

  p_fast_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ($past(act_sel) != 3'd0)) |-> $past(fast_tick));

  p_slow_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ($past(act_sel) == 3'd0)) |-> $past(slow_tick));

  p_leave_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && (sel_wdata != 3'd0) && (sel_q == 3'd0)) |=>
      (!freq_stable && (act_sel == $past(sel_wdata))));

  p_stable_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_stable) |-> $past(stab_done));

  p_keep_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && (sel_wdata != 3'd0) && (sel_q != 3'd0) && freq_stable) |=> freq_stable);

  p_to_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && (sel_wdata == 3'd0)) |=>
      ((act_sel == 3'd0) && (freq_stable == $past(freq_stable))));

  p_same_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && (sel_wdata == sel_q)) |=> (sel_q == $past(sel_q)));

  p_hold_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && (sel_wdata != 3'd0) && (sel_q != 3'd0) && freq_stable &&
     (sel_wdata != act_sel)) |=> (act_sel == $past(act_sel)));
endmodule

bind osc_freq_select osc_freq_select_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fast_tick   (fast_tick),
  .slow_tick   (slow_tick),
  .sel_wr      (sel_wr),
  .sel_wdata   (sel_wdata),
  .clk_en      (clk_en),
  .freq_stable (freq_stable),
  .sel_q       (sel_q),
  .act_sel     (act_sel),
  .stab_done   (stab_done)
);

// File: tb/test_osc_freq_select.sv
module test_osc_freq_select;
  localparam int STAB   = 40;
  localparam int SLOW_P = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_tick = 1'b0;
  logic       slow_tick = 1'b0;
  logic       sel_wr = 1'b0;
  logic [2:0] sel_wdata = 3'd0;
  logic       clk_en, freq_stable;
  logic [2:0] sel_q;
  int         checks = 0;
  int         failures = 0;
  int         scnt = 0;

  osc_freq_select #(.STAB_TICKS(STAB)) i_osc_freq_select (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .clk_en(clk_en),
    .freq_stable(freq_stable), .sel_q(sel_q)
  );

  always #2 clk = ~clk;

  // Fast tick every second cycle; slow tick every SLOW_P cycles.
  always @(negedge clk) begin
    fast_tick <= ~fast_tick;
    if (scnt == SLOW_P - 1) begin scnt <= 0; slow_tick <= 1'b1; end
    else begin scnt <= scnt + 1; slow_tick <= 1'b0; end
  end

  function automatic int period(input int s);
    return 2 << (7 - s);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_sel(input logic [2:0] v);
    @(negedge clk);
    sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  // Watch pulses for a number of cycles; gaps must be a or b.
  task automatic watch(input int cycles, input int a, input int b,
                       output bit bad, output int bad_val, output int last_gap,
                       output int first_b, output bit saw_lo, output bit saw_hi);
    int last = -1;
    bad = 0; bad_val = 0; last_gap = 0; first_b = -1; saw_lo = 0; saw_hi = 0;
    for (int c = 1; c <= cycles; c++) begin
      @(negedge clk);
      if (freq_stable) saw_hi = 1; else saw_lo = 1;
      if (clk_en) begin
        if (last >= 0) begin
          last_gap = c - last;
          if (last_gap != a && last_gap != b) begin bad = 1; bad_val = last_gap; end
          if (last_gap == b && first_b < 0) first_b = c;
        end
        last = c;
      end
    end
  endtask

  task automatic check_rate(input int iv, input string tag);
    bit bad, lo, hi; int bv, lg, fb;
    watch(3 * iv + 12, iv, iv, bad, bv, lg, fb, lo, hi);
    check(!bad && lg == iv, tag, bad ? bv : lg, iv);
  endtask

  // Count fast ticks until freq_stable rises; n carries ticks already counted.
  task automatic wait_rise(inout int n, output int first_pulse);
    first_pulse = -1;
    for (int c = 1; c < 20000; c++) begin
      @(negedge clk);
      if (fast_tick) n++;
      if (clk_en && first_pulse < 0) first_pulse = c;
      if (freq_stable) return;
    end
  endtask

  task automatic t_reset;
    check(freq_stable == 1'b0, "R1 stable after reset", int'(freq_stable), 0);
    check(sel_q == 3'd0, "R1 field after reset", int'(sel_q), 0);
    check_rate(SLOW_P, "R3 slow gap after reset");
  endtask

  task automatic t_leave_slow(input logic [2:0] s);
    int n = 0; int fp;
    write_sel(s);
    check(freq_stable == 1'b0, "R4 flag low after leaving slow", int'(freq_stable), 0);
    wait_rise(n, fp);
    check(n == STAB, "R5 ticks until stable", n, STAB);
    check(fp > 0 && fp <= period(s) + 2, "R4 first new-rate pulse", fp, period(s) + 2);
    check_rate(period(s), "R2 rate after warm-up");
  endtask

  task automatic t_fast_switch(input logic [2:0] f, input logic [2:0] t);
    int oi = period(f); int ni = period(t);
    bit bad, lo, hi; int bv, lg, fb;
    write_sel(t);
    watch(12 * ni + 2 * oi + 40, oi, ni, bad, bv, lg, fb, lo, hi);
    check(!bad, "R7 gap during fast switch", bv, ni);
    check(!lo, "R6 flag kept during fast switch", int'(lo), 0);
    check(fb >= 8 * ni, "R6 new rate not before eight edges", fb, 8 * ni);
    check(lg == ni, "R2 rate after fast switch", lg, ni);
    check(sel_q == t, "R2 field readback", int'(sel_q), int'(t));
  endtask

  task automatic t_to_slow;
    bit bad, lo, hi; int bv, lg, fb;
    write_sel(3'd0);
    watch(3 * SLOW_P + 12, SLOW_P, SLOW_P, bad, bv, lg, fb, lo, hi);
    check(!bad && lg == SLOW_P, "R8 slow rate after zero write", lg, SLOW_P);
    check(!lo, "R8 flag unchanged by zero write", int'(lo), 0);
  endtask

  task automatic t_same_write;
    int n = 0; int fp;
    write_sel(3'd6);
    check(freq_stable == 1'b0, "R4 flag low from slow", int'(freq_stable), 0);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (fast_tick) n++;
    end
    sel_wr = 1'b1; sel_wdata = 3'd6;
    @(negedge clk);
    if (fast_tick) n++;
    sel_wr = 1'b0;
    wait_rise(n, fp);
    check(n == STAB, "R9 same write keeps window", n, STAB);
    check(sel_q == 3'd6, "R9 field unchanged", int'(sel_q), 6);
    check_rate(period(6), "R9 rate unchanged");
  endtask

  task automatic t_restart_warmup;
    int n = 0; int fp;
    write_sel(3'd0);
    write_sel(3'd3);
    repeat (40) @(negedge clk);
    write_sel(3'd7);
    wait_rise(n, fp);
    check(n == STAB, "R10 window restarts at second write", n, STAB);
    check(fp > 0 && fp <= period(7) + 2, "R10 output at newest rate", fp, period(7) + 2);
    check_rate(period(7), "R10 rate after restart");
  endtask

  task automatic t_zero_in_warmup;
    bit bad, lo, hi; int bv, lg, fb; int n = 0; int fp;
    write_sel(3'd0);
    write_sel(3'd2);
    repeat (20) @(negedge clk);
    write_sel(3'd0);
    watch(3 * SLOW_P + 12, SLOW_P, SLOW_P, bad, bv, lg, fb, lo, hi);
    check(!hi, "R8 flag stays low after zero write in window", int'(hi), 0);
    check(!bad && lg == SLOW_P, "R8 slow rate in window", lg, SLOW_P);
    write_sel(3'd7);
    wait_rise(n, fp);
    check(n == STAB, "R5 window after return", n, STAB);
  endtask

  task automatic t_retarget;
    bit bad, lo, hi; int bv, lg, fb;
    write_sel(3'd1);
    watch(100, period(7), period(7), bad, bv, lg, fb, lo, hi);
    check(!bad, "R11 old rate held while counting", bv, period(7));
    write_sel(3'd2);
    check(sel_q == 3'd2, "R11 field retargeted", int'(sel_q), 2);
    watch(12 * period(2) + 2 * period(7) + 40, period(7), period(2), bad, bv, lg, fb, lo, hi);
    check(!bad && lg == period(2), "R11 retarget reaches new rate", bad ? bv : lg, period(2));
    check(!lo, "R6 flag kept across retarget", int'(lo), 0);
    write_sel(3'd1);
    repeat (50) @(negedge clk);
    write_sel(3'd2);
    watch(12 * period(1), period(2), period(2), bad, bv, lg, fb, lo, hi);
    check(!bad && lg == period(2), "R11 return to active rate cancels change", bad ? bv : lg, period(2));
    check(sel_q == 3'd2, "R11 field after cancel", int'(sel_q), 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_leave_slow(3'd5);
    t_fast_switch(3'd5, 3'd7);
    t_fast_switch(3'd7, 3'd1);
    t_fast_switch(3'd1, 3'd3);
    t_fast_switch(3'd3, 3'd6);
    t_fast_switch(3'd6, 3'd2);
    t_fast_switch(3'd2, 3'd4);
    t_to_slow();
    t_same_write();
    t_restart_warmup();
    t_zero_in_warmup();
    t_retarget();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule